// File: doc/BRIEF.md
# Runtime-Configurable SPI Word Master

This block moves one word at a time over a four-wire SPI link as the bus master. A word and its length are offered on a valid/ready input. Clock mode, bit order, chip-select polarity and SCK rate are configuration inputs, and the block captures them together with the word. While the word is in flight the block drives SCK, MOSI and one chip select and samples MISO. Every word is full duplex: each SCK period sends one bit and receives one bit. When the last bit has been exchanged, chip select is released and the received word appears for one cycle with a valid pulse.

The input stream follows valid/ready rules. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the engine is idle, so a producer holding `tx_valid` high simply waits. The output has no ready: `rx_valid` is a single-cycle pulse, and the consumer must take `rx_data` in that cycle (it stays unchanged until the next accepted word). SCK is derived from the system clock. Each half period lasts `cfg_div + 1` system clocks, and SCK moves only while bits are being exchanged.

Top module: `spi_word_master`

## Requirements
- R1: After reset and whenever idle, `tx_ready` is 1, `rx_valid` is 0, `sck` equals `cfg_mode[1]` and `cs` is at its inactive level.
- R2: A word and all configuration inputs are captured on the edge where `tx_valid && tx_ready`. `tx_ready` is then 0 until the word completes. Changes to `tx_data`, `tx_len_m1` or any `cfg_*` input while busy do not affect the word in flight, and `tx_valid` without `tx_ready` starts nothing.
- R3: Chip select stays active for exactly (2N+1)·(cfg_div+1) clock cycles, where N is the word length. Within that window SCK toggles exactly 2N times. Consecutive SCK changes, and the first change after chip select asserts, are cfg_div+1 cycles apart.
- R4: `cfg_mode[1]` is CPOL. With CPOL=0, SCK idles low and the leading edge of each bit rises. With CPOL=1, SCK idles high and the leading edge falls.
- R5: `cfg_mode[0]` is CPHA. With CPHA=0, the first bit is on MOSI from the cycle chip select asserts, both ends sample on leading edges, and data changes on trailing edges. With CPHA=1, data changes on leading edges and both ends sample on trailing edges.
- R6: With `cfg_lsb_first`=0, bit N-1 of the word is sent first and the first received bit becomes bit N-1 of `rx_data`. With `cfg_lsb_first`=1, bit 0 is sent first and the first received bit becomes bit 0.
- R7: `tx_len_m1` holds N-1, so 0..31 selects 1 to 32 bits (for example 7, 11 and 19 for 8, 12 and 20 bits). Bits of `tx_data` at positions N and above are never sent.
- R8: `rx_data` is right-aligned: bits N-1..0 hold the received word and all higher bits are 0.
- R9: With `cfg_cs_high`=0, `cs` is active low. With `cfg_cs_high`=1, it is active high. While idle, the level of `cs` follows the live `cfg_cs_high` input.
- R10: `rx_valid` is high for one cycle, in the first cycle chip select is inactive again, and `tx_ready` is high in that same cycle, so a word offered then is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Engine idle, word can be taken |
| tx_data | input | DATA_W | Word to send, right-aligned |
| tx_len_m1 | input | LEN_W | Word length minus one |
| cfg_mode | input | 2 | Bit 1 = CPOL, bit 0 = CPHA |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_cs_high | input | 1 | 1 = chip select active high |
| cfg_div | input | DIV_W | SCK half period minus one, in clocks |
| rx_valid | output | 1 | One-cycle pulse: received word ready |
| rx_data | output | DATA_W | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select |

## Verification
The end of one word and the acceptance of the next can fall in the same cycle. The cycle in which `rx_valid` pulses is also the cycle in which `tx_ready` is high. The bench waits for the done pulse, offers a new word with a different mode in that very cycle, and checks three things: that `tx_ready` was high alongside `rx_valid`, that chip select went inactive for exactly one sampled cycle, and that the second word's data, SCK timing and edge count match a slave model as if it had been started from idle. A bus slave model that follows CPOL/CPHA independently of the design supplies MISO and checks what it received on MOSI.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  typedef enum logic [1:0] {
    SPI_MODE0 = 2'd0,
    SPI_MODE1 = 2'd1,
    SPI_MODE2 = 2'd2,
    SPI_MODE3 = 2'd3
  } spi_mode_e;

  function automatic logic mode_cpol(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_cpha(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_bit_seq.sv
module spi_bit_seq #(
  parameter  int LEN_W = 5,
  localparam int EW    = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             idle_cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] nbits_m1,
  output logic             busy,
  output logic             sck_q,
  output logic             sample_en,
  output logic             shift_en,
  output logic             finish
);

  logic [EW-1:0] edge_idx;
  logic [EW-1:0] edge_last;
  logic          edge_now;
  logic          is_lead;

  assign edge_last = EW'({nbits_m1, 1'b0}) + EW'(2);
  assign edge_now  = busy && tick && (edge_idx != edge_last);
  assign finish    = busy && tick && (edge_idx == edge_last);
  assign is_lead   = ~edge_idx[0];

  always_comb begin
    if (cpha) begin
      sample_en = edge_now && !is_lead;
      shift_en  = edge_now && is_lead && (edge_idx != '0);
    end else begin
      sample_en = edge_now && is_lead;
      shift_en  = edge_now && !is_lead && (edge_idx != edge_last - EW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck_q    <= 1'b0;
      edge_idx <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      sck_q    <= idle_cpol;
      edge_idx <= '0;
    end else if (finish) begin
      busy     <= 1'b0;
    end else if (edge_now) begin
      sck_q    <= ~sck_q;
      edge_idx <= edge_idx + EW'(1);
    end
  end

  // R3
  sck_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sck_q != $past(sck_q))) |-> $past(tick));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter  int DATA_W = 32,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              busy,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  nbits_m1,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  assign mosi    = busy ? (lsb_first ? tx_sh[0] : tx_sh[nbits_m1]) : 1'b0;
  assign rx_word = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (start) begin
      tx_sh <= load_data;
      rx_sh <= '0;
    end else begin
      if (shift_en)
        tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
      if (sample_en)
        rx_sh <= lsb_first ? ((rx_sh >> 1) | (DATA_W'(miso) << nbits_m1))
                           : {rx_sh[DATA_W-2:0], miso};
    end
  end

  // R5
  mosi_steady_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !start) |=> $stable(mosi) || shift_en == 1'b0);

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DIV_W  = 8,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  tx_len_m1,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cs_high,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs
);

  logic             accept;
  logic             busy;
  logic             tick;
  logic             sck_q;
  logic             sample_en;
  logic             shift_en;
  logic             finish;
  logic             cpha_q;
  logic             lsb_q;
  logic             csh_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;

  assign tx_ready = !busy;
  assign accept   = tx_valid && tx_ready;
  assign sck      = busy ? sck_q : mode_cpol(cfg_mode);
  assign cs       = busy ? csh_q : ~cfg_cs_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
      csh_q    <= 1'b0;
      div_q    <= '0;
      len_q    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= finish;
      if (accept) begin
        cpha_q <= mode_cpha(cfg_mode);
        lsb_q  <= cfg_lsb_first;
        csh_q  <= cfg_cs_high;
        div_q  <= cfg_div;
        len_q  <= tx_len_m1;
      end
    end
  end

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  spi_bit_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .tick     (tick),
    .idle_cpol(mode_cpol(cfg_mode)),
    .cpha     (cpha_q),
    .nbits_m1 (len_q),
    .busy     (busy),
    .sck_q    (sck_q),
    .sample_en(sample_en),
    .shift_en (shift_en),
    .finish   (finish)
  );

  spi_word_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .load_data(tx_data),
    .busy     (busy),
    .lsb_first(lsb_q),
    .nbits_m1 (len_q),
    .shift_en (shift_en),
    .sample_en(sample_en),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_data)
  );

  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_ready);

  // R10
  done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> tx_ready);

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (({1'b0, rx_data} >> (LEN_W + 1)'(len_q + 1'b1)) == '0));

endmodule

// File: tb/spi_word_master_test.sv
module spi_word_master_test;

  typedef struct packed {
    logic [1:0]  mode;
    logic        lsb;
    logic        csh;
    logic [7:0]  div;
    logic [4:0]  lenm1;
    logic [31:0] tx;
    logic [31:0] sw;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 1'b0, 1'b0, 8'd1, 5'd7,  32'h0000_00A5, 32'h0000_003C},
    '{2'd1, 1'b0, 1'b0, 8'd0, 5'd7,  32'h0000_005A, 32'h0000_00C3},
    '{2'd2, 1'b1, 1'b1, 8'd2, 5'd11, 32'h0000_0ABC, 32'h0000_0123},
    '{2'd3, 1'b1, 1'b0, 8'd1, 5'd19, 32'h0009_1234, 32'h000A_5A5A},
    '{2'd0, 1'b1, 1'b1, 8'd0, 5'd31, 32'hDEAD_BEEF, 32'h1234_5678},
    '{2'd3, 1'b0, 1'b1, 8'd3, 5'd0,  32'h0000_0001, 32'h0000_0001},
    '{2'd1, 1'b1, 1'b0, 8'd0, 5'd0,  32'h0000_0000, 32'h0000_0001},
    '{2'd2, 1'b0, 1'b0, 8'd0, 5'd15, 32'hFFFF_1234, 32'hFFFF_8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic [4:0]  tx_len_m1 = '0;
  logic [1:0]  cfg_mode = 2'd2;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_cs_high = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        rx_valid;
  logic [31:0] rx_data;
  logic        sck;
  logic        mosi;
  logic        miso = 1'b0;
  logic        cs;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  spi_word_master uut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_len_m1(tx_len_m1), .cfg_mode(cfg_mode),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cs_high(cfg_cs_high), .cfg_div(cfg_div),
    .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .mosi(mosi),
    .miso(miso), .cs(cs)
  );

  // slave model state, kept from the bench's own copy of the settings
  logic        xfer_on = 1'b0;
  logic [1:0]  sl_mode = '0;
  logic        sl_lsb = 1'b0;
  logic        sl_csh = 1'b0;
  int          sl_div = 0;
  int          sl_n = 1;
  logic [31:0] sl_word = '0;
  logic [31:0] s_rx = '0;
  int          sl_k = 0;
  int          lead_cnt = 0;
  int          trail_cnt = 0;
  int          gap = 0;
  logic        gap_bad = 1'b0;
  logic        prev_sck = 1'b0;
  logic        prev_act = 1'b0;

  function automatic int bpos(input int k);
    return sl_lsb ? k : (sl_n - 1 - k);
  endfunction

  function automatic logic [31:0] mask_n(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(cs) begin
    if (xfer_on && cs === sl_csh) begin
      sl_k = 0; lead_cnt = 0; trail_cnt = 0; s_rx = '0;
      miso = sl_word[bpos(0)];
    end
  end

  always @(sck) begin
    if (xfer_on && cs === sl_csh && (sck === 1'b0 || sck === 1'b1)) begin
      if (sck !== sl_mode[1]) begin
        if (!sl_mode[0]) begin
          if (lead_cnt < sl_n) s_rx[bpos(lead_cnt)] = mosi;
        end else if (lead_cnt > 0) begin
          sl_k++;
          miso = (sl_k < sl_n) ? sl_word[bpos(sl_k)] : 1'b0;
        end
        lead_cnt++;
      end else begin
        if (!sl_mode[0]) begin
          sl_k++;
          miso = (sl_k < sl_n) ? sl_word[bpos(sl_k)] : 1'b0;
        end else if (trail_cnt < sl_n) begin
          s_rx[bpos(trail_cnt)] = mosi;
        end
        trail_cnt++;
      end
    end
  end

  // half-period monitor (R3)
  always @(negedge clk) begin
    if (xfer_on && cs === sl_csh) begin
      if (!prev_act) begin
        gap = 1; gap_bad = 1'b0; prev_sck = sck;
      end else if (sck !== prev_sck) begin
        if (gap != sl_div + 1) gap_bad = 1'b1;
        gap = 1; prev_sck = sck;
      end else begin
        gap++;
      end
      prev_act = 1'b1;
    end else begin
      prev_act = 1'b0;
    end
  end

  // called at a negedge; returns at the first negedge after acceptance
  task automatic apply(input vec_t v);
    sl_mode = v.mode; sl_lsb = v.lsb; sl_csh = v.csh; sl_div = int'(v.div);
    sl_n = int'(v.lenm1) + 1; sl_word = v.sw; xfer_on = 1'b1;
    cfg_mode = v.mode; cfg_lsb_first = v.lsb; cfg_cs_high = v.csh;
    cfg_div = v.div; tx_len_m1 = v.lenm1; tx_data = v.tx; tx_valid = 1'b1;
    check(tx_ready === 1'b1, "R2 ready before accept", 32'(tx_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(cs === v.csh, "R9 cs active level", 32'(cs), 32'(v.csh));
    if (!v.mode[0])
      check(mosi === v.tx[bpos(0)], "R5 first bit at cs assert", 32'(mosi),
            32'(v.tx[bpos(0)]));
  endtask

  task automatic wait_done(input int init, output int cs_cycles);
    int guard;
    cs_cycles = init;
    guard = 0;
    while (rx_valid !== 1'b1 && guard < 5000) begin
      if (cs === sl_csh) cs_cycles++;
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000)
      check(1'b0, "R10 watchdog waiting for done", 32'(guard), 32'd0);
  endtask

  task automatic verify(input vec_t v, input int cs_cycles);
    int n;
    n = int'(v.lenm1) + 1;
    check(rx_data === (v.sw & mask_n(n)), "R5/R6/R7/R8 received word",
          rx_data, v.sw & mask_n(n));
    check(s_rx === (v.tx & mask_n(n)), "R5/R6/R7 word seen by slave",
          s_rx, v.tx & mask_n(n));
    check(cs_cycles == (2*n + 1) * (int'(v.div) + 1), "R3 chip select window",
          32'(cs_cycles), 32'((2*n + 1) * (int'(v.div) + 1)));
    check(lead_cnt == n && trail_cnt == n && !gap_bad, "R3/R4 edge count and spacing",
          32'(lead_cnt + trail_cnt), 32'(2*n));
    check(tx_ready === 1'b1, "R10 ready with done", 32'(tx_ready), 32'd1);
  endtask

  task automatic after_idle(input vec_t v);
    @(negedge clk);
    check(rx_valid === 1'b0, "R10 done is one cycle", 32'(rx_valid), 32'd0);
    check(sck === v.mode[1], "R1/R4 sck rests at CPOL", 32'(sck), 32'(v.mode[1]));
    xfer_on = 1'b0;
  endtask

  initial begin
    repeat (1500000 / 20) @(posedge clk);
    check(1'b0, "R1 global watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    vec_t w;
    logic stayed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_ready === 1'b1, "R1 ready after reset", 32'(tx_ready), 32'd1);
    check(rx_valid === 1'b0, "R1 no done after reset", 32'(rx_valid), 32'd0);
    check(sck === 1'b1, "R1 sck idle mode 2", 32'(sck), 32'd1);
    check(cs === 1'b1, "R1 cs idle active-low", 32'(cs), 32'd1);
    cfg_mode = 2'd0;
    @(negedge clk);
    check(sck === 1'b0, "R1 sck idle mode 0", 32'(sck), 32'd0);

    // R9 idle level follows live setting
    cfg_cs_high = 1'b1;
    @(negedge clk);
    check(cs === 1'b0, "R9 idle cs when active-high", 32'(cs), 32'd0);
    cfg_cs_high = 1'b0;
    @(negedge clk);
    check(cs === 1'b1, "R9 idle cs when active-low", 32'(cs), 32'd1);

    // R2 nothing starts without tx_valid
    stayed = 1'b1;
    tx_data = 32'hFFFF_FFFF;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cs !== 1'b1 || sck !== 1'b0) stayed = 1'b0;
    end
    check(stayed, "R2 no start without valid", 32'(stayed), 32'd1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      wait_done(0, cyc);
      verify(VECS[i], cyc);
      after_idle(VECS[i]);
    end

    // R2 changes while busy are ignored
    w = '{2'd1, 1'b0, 1'b0, 8'd2, 5'd15, 32'h0000_C0DE, 32'h0000_7E81};
    apply(w);
    cyc = 0;
    cfg_mode = 2'd2; cfg_lsb_first = 1'b1; cfg_div = 8'd0; tx_len_m1 = 5'd3;
    tx_data = 32'h0000_FFFF; tx_valid = 1'b1; cfg_cs_high = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check(tx_ready === 1'b0 && cs === 1'b0, "R2 busy ignores new inputs",
            {30'd0, tx_ready, cs}, 32'd0);
      if (cs === sl_csh) cyc++;
      @(negedge clk);
    end
    cfg_cs_high = 1'b0; tx_valid = 1'b0; cfg_mode = 2'd1;
    wait_done(cyc, cyc);
    verify(w, cyc);
    after_idle(w);

    // R10 back-to-back: offer next word in the done cycle
    w = '{2'd0, 1'b0, 1'b0, 8'd1, 5'd7, 32'h0000_0096, 32'h0000_0069};
    apply(w);
    wait_done(0, cyc);
    verify(w, cyc);
    w = '{2'd3, 1'b1, 1'b0, 8'd0, 5'd11, 32'h0000_0F0A, 32'h0000_0A5C};
    check(cs === 1'b1, "R10 cs inactive in done cycle", 32'(cs), 32'd1);
    apply(w);
    wait_done(0, cyc);
    verify(w, cyc);
    after_idle(w);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule